// File: doc/BRIEF.md
# Kick-Updated Fractional Clock Divider

This block turns a parent clock into a train of single-cycle enable pulses whose
average rate is the parent rate times `mult / 32`. A five-bit accumulator adds the
active multiplier every cycle, and its carry out is the enable. Over any 32
consecutive cycles exactly `mult` pulses appear, spread as evenly as integer
spacing allows.

Software changes the ratio in two steps. First it writes a staged code into a ratio
register. The code is inverse-encoded: the multiplier is 32 minus the code. Then it
sets a kick bit in a control register. The hardware waits for the end of the current
32-cycle period and swaps in the staged code there. On the next cycle it clears the
kick bit by itself. Software polls the kick status as a busy flag and gives up after
a timeout of its own choosing.

Top module: `kick_frac_div`

## Requirements
- R1: After reset the active multiplier is 32 (code 0), the kick status is low and an enable pulse appears in every cycle.
- R2: The active multiplier equals 32 minus the 5-bit code written at bits `FIELD_LSB+4..FIELD_LSB` (default bits 12..8) of the ratio register (`bus_addr == RATIO_ADDR`), so it always lies in 1..32.
- R3: While the multiplier holds steady, any 32 consecutive cycles contain exactly `mult` enable pulses.
- R4: A write to the ratio register without a kick leaves the active multiplier unchanged.
- R5: A write to the control register (`bus_addr == KICK_ADDR`) with bit 31 set raises the kick status on the following cycle.
- R6: A pending kick applies the staged code only at a 32-cycle period boundary. The kick status falls exactly one cycle after the active multiplier changes, and no more than 34 cycles after the kick write.
- R7: Writes to the ratio register while the kick status is high are ignored.
- R8: A write to the control register with bit 31 clear has no effect on the kick status or on the multiplier.
- R9: The gap between consecutive enable pulses is always either floor(32/mult) or ceil(32/mult) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register write address |
| bus_wdata | input | 32 | Register write data |
| clk_en | output | 1 | Enable pulse train |
| kick_busy | output | 1 | Kick bit: high while a ratio change is pending |
| mult_o | output | 6 | Active multiplier, 1..32 |

## Verification
If the accumulator or the period counter drifted from its true state, the pulse count
in a 32-cycle window and the spacing between pulses would be wrong on the next window.
That shows up as a miscount or a bad gap within 32 cycles. A staged code latched at
the wrong time, or a kick that never clears, shows on `mult_o` and `kick_busy`.
Each kick has a 34-cycle completion window, so such a fault appears inside that
window. The bench sweeps all 32 codes and checks each of these effects for every code.

// File: rtl/kick_frac_div.sv
module kick_frac_div #(
  parameter int ADDR_W = 4,
  parameter int FIELD_LSB = 8,
  parameter logic [ADDR_W-1:0] RATIO_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] KICK_ADDR = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              clk_en,
  output logic              kick_busy,
  output logic [5:0]        mult_o
);
  localparam int FW = 5;
  localparam int PW = FW + 1;
  localparam int KICK_BIT = 31;
  localparam logic [PW-1:0] FULL = PW'(32);

  logic [FW-1:0] staged_q, phase_q, acc_q;
  logic [PW-1:0] mult_q, sum;
  logic          kick_q, apply_q;

  wire wr_ratio = bus_wr && (bus_addr == RATIO_ADDR);
  wire wr_kick  = bus_wr && (bus_addr == KICK_ADDR) && bus_wdata[KICK_BIT];
  wire boundary = &phase_q;
  wire take     = kick_q && !apply_q && boundary;

  assign sum       = {1'b0, acc_q} + mult_q;
  assign clk_en    = sum[PW-1];
  assign kick_busy = kick_q;
  assign mult_o    = mult_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= '0;
      phase_q  <= '0;
      acc_q    <= '0;
      mult_q   <= FULL;
      kick_q   <= 1'b0;
      apply_q  <= 1'b0;
    end else begin
      phase_q <= phase_q + 1'b1;
      acc_q   <= sum[FW-1:0];
      apply_q <= take;
      if (wr_ratio && !kick_q) staged_q <= bus_wdata[FIELD_LSB +: FW];
      if (take) mult_q <= FULL - {1'b0, staged_q};
      if (apply_q) kick_q <= 1'b0;
      else if (wr_kick) kick_q <= 1'b1;
    end
  end

  p_mult_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_q != '0) && (mult_q <= FULL));

  p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_q == FULL) |-> clk_en);

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_q |=> $stable(mult_q));

  p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mult_q) |-> (phase_q == '0));

  p_kick_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kick_q) |-> (phase_q == FW'(1)));

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_q && wr_ratio) |=> $stable(staged_q));
endmodule

// File: tb/sim_kick_frac_div.sv
module sim_kick_frac_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        clk_en, kick_busy;
  logic [5:0]  mult_o;
  int checks = 0;
  int errors = 0;
  int cur_mult = 32;

  always #2 clk = ~clk;

  kick_frac_div u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .clk_en(clk_en), .kick_busy(kick_busy), .mult_o(mult_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic window(input int m);
    int cnt = 0;
    int last = -1;
    int lo = 32 / m;
    int hi = (32 + m - 1) / m;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (clk_en) begin
        if (last >= 0)
          chk((i - last) == lo || (i - last) == hi, "R9 gap", i - last, lo);
        last = i;
        cnt++;
      end
    end
    chk(cnt == m, "R3 pulses per window", cnt, m);
  endtask

  task automatic kick_and_wait(input int exp_mult);
    int chg = 0;
    int fell = 0;
    int prev = cur_mult;
    wr(4'h4, 32'h8000_0000);
    chk(kick_busy == 1'b1, "R5 kick status set", kick_busy, 1);
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (int'(mult_o) != prev && chg == 0) chg = n;
      if (!kick_busy) begin
        fell = n;
        break;
      end
    end
    chk(fell != 0 && fell <= 34, "R6 kick clears in time", fell, 34);
    if (exp_mult != prev) chk(fell - chg == 1, "R6 clear one cycle after change", fell - chg, 1);
    chk(int'(mult_o) == exp_mult, "R2 active multiplier", mult_o, exp_mult);
    cur_mult = exp_mult;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mult_o == 6'd32, "R1 reset multiplier", mult_o, 32);
    chk(kick_busy == 1'b0, "R1 reset kick", kick_busy, 0);
    chk(clk_en == 1'b1, "R1 full rate pulse", clk_en, 1);
    window(32);

    for (int k = 1; k <= 32; k++) begin
      int f = k % 32;
      wr(4'h0, 32'(f) << 8);
      kick_and_wait(32 - f);
      window(32 - f);
    end

    wr(4'h0, 32'(20) << 8);
    repeat (40) @(negedge clk);
    chk(int'(mult_o) == cur_mult, "R4 staged write alone", mult_o, cur_mult);
    window(cur_mult);

    wr(4'h4, 32'h7FFF_FFFF);
    chk(kick_busy == 1'b0, "R8 kick write of zero", kick_busy, 0);
    repeat (40) @(negedge clk);
    chk(kick_busy == 1'b0, "R8 kick stays clear", kick_busy, 0);
    chk(int'(mult_o) == cur_mult, "R8 multiplier unchanged", mult_o, cur_mult);

    kick_and_wait(12);

    wr(4'h0, 32'(3) << 8);
    wr(4'h4, 32'h8000_0000);
    wr(4'h0, 32'(29) << 8);
    for (int n = 0; n < 40 && kick_busy; n++) @(negedge clk);
    chk(int'(mult_o) == 29, "R7 busy write ignored", mult_o, 29);
    cur_mult = 29;
    window(29);

    wr(4'h0, 32'(31) << 8);
    kick_and_wait(1);
    window(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule